// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block drives one bus-master disk DMA channel through a table of scatter-gather descriptors held in host memory. A start pulse supplies the table base address, the number of bytes waiting in the device buffer and the transfer direction. The walker reads descriptors one at a time over a memory request port. Each descriptor gives a buffer address and a byte count. The walker then issues data-chunk requests that cover the device bytes, taking them from one buffer region after another.

Each chunk request names a host address, a length and a direction. The data path outside the block carries out the actual byte movement. The walk ends in one of two ways. A buffer-completed pulse fires when the device byte count has been fully consumed. A table-exhausted pulse fires when no more descriptors are available. That happens either after the descriptor flagged as final has been used up, or when the table pointer has moved one 4 KiB page past the base, which stops a table that was never terminated.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset, `busy`, `mreq_valid`, `done_ok` and `done_exh` are all low.
- R2: A descriptor fetch is a request with `mreq_desc`=1, `mreq_write`=0, `mreq_len`=8 and `mreq_addr` equal to the current table pointer. In the response word, bits 31:0 hold the buffer address and bits 63:32 hold the size word.
- R3: The byte count of a descriptor is size-word bits 15:1 times two, so bit 0 is ignored. A count of zero stands for 65536 bytes.
- R4: Size-word bit 31 marks the final descriptor. Once that descriptor is used up with device bytes still left, `done_exh` pulses for one cycle and the walk ends.
- R5: A descriptor is fetched only when the current descriptor has zero bytes left. Fetch addresses run base, base+8, base+16 and so on.
- R6: No fetch is issued once the table pointer is 4096 or more bytes past the base. In that case `done_exh` pulses instead.
- R7: Each data chunk has `mreq_desc`=0. Its length is the smaller of the bytes left in the device buffer and the bytes left in the current descriptor. Its address continues where the previous chunk of the same descriptor stopped. `mreq_write` equals the `to_mem` value captured at start (1 means a memory write).
- R8: When the device byte count reaches zero, `done_ok` pulses for one cycle, even if the descriptor is final. A start with zero device bytes issues no request and goes straight to `done_ok`. `done_ok` and `done_exh` never pulse together.
- R9: A start clears the remaining length, the buffer address and the final flag, and reloads the table pointer from `table_base`. Nothing left over from an earlier walk is reused.
- R10: While `mreq_valid` is high and `mreq_ready` is low, the request holds its fields. At most one descriptor fetch is outstanding, and no request is issued while one is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| table_base | input | AW | Descriptor table base address |
| dev_bytes | input | DEV_W | Bytes in the device buffer |
| to_mem | input | 1 | 1: chunks write memory, 0: chunks read memory |
| busy | output | 1 | Walk in progress |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_desc | output | 1 | Request is a descriptor fetch |
| mreq_write | output | 1 | Request writes memory |
| mreq_addr | output | AW | Request address |
| mreq_len | output | 17 | Request length in bytes |
| mrsp_valid | input | 1 | Descriptor response valid |
| mrsp_data | input | 64 | Descriptor response (little-endian pair) |
| done_ok | output | 1 | Buffer-completed pulse |
| done_exh | output | 1 | Table-exhausted pulse |

## Verification
A table of walks is run against a reference walk built from the requirements. These walks cover a single final descriptor that exactly matches the buffer, two descriptors with an odd size word, a zero-count descriptor, and a buffer that ends partway through a second descriptor. Together they separate the 64 KiB rule, the bit-0 mask and the priority of draining over exhaustion. An unterminated 512-entry table shows that the page guard stops the walk. A repeat of an earlier walk after a partial one shows that start clears leftover state. Walks with a stalling request port and a zero-byte start cover the handshake and the no-request path.

// File: rtl/sg_desc_walker.sv
module sg_desc_walker #(
  parameter int AW         = 32,
  parameter int DEV_W      = 20,
  parameter int PAGE_BYTES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    table_base,
  input  logic [DEV_W-1:0] dev_bytes,
  input  logic             to_mem,
  output logic             busy,
  output logic             mreq_valid,
  input  logic             mreq_ready,
  output logic             mreq_desc,
  output logic             mreq_write,
  output logic [AW-1:0]    mreq_addr,
  output logic [16:0]      mreq_len,
  input  logic             mrsp_valid,
  input  logic [63:0]      mrsp_data,
  output logic             done_ok,
  output logic             done_exh
);
  localparam int LEN_W      = 17;
  localparam int DESC_BYTES = 8;
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(65536);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_FREQ, S_FWAIT, S_CREQ} st_t;

  st_t               st;
  logic [AW-1:0]     base_q, ptr_q, addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              last_q, dir_q;
  logic [DEV_W-1:0]  left_q;

  logic [AW-1:0]     walked;
  logic              guard_hit;
  logic [15:0]       raw_cnt;
  logic [LEN_W-1:0]  new_len, chunk;

  assign walked    = ptr_q - base_q;
  assign guard_hit = walked >= AW'(PAGE_BYTES);
  assign raw_cnt   = {mrsp_data[47:33], 1'b0};
  assign new_len   = (raw_cnt == 16'd0) ? FULL_LEN : LEN_W'(raw_cnt);
  assign chunk     = (32'(left_q) < 32'(rem_q)) ? LEN_W'(left_q) : rem_q;

  assign busy       = (st != S_IDLE);
  assign mreq_valid = (st == S_FREQ) || (st == S_CREQ);
  assign mreq_desc  = (st == S_FREQ);
  assign mreq_write = (st == S_CREQ) && dir_q;
  assign mreq_addr  = (st == S_FREQ) ? ptr_q : addr_q;
  assign mreq_len   = (st == S_FREQ) ? LEN_W'(DESC_BYTES) : chunk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      base_q   <= '0;
      ptr_q    <= '0;
      addr_q   <= '0;
      rem_q    <= '0;
      last_q   <= 1'b0;
      dir_q    <= 1'b0;
      left_q   <= '0;
      done_ok  <= 1'b0;
      done_exh <= 1'b0;
    end else begin
      done_ok  <= 1'b0;
      done_exh <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base_q <= table_base;
          ptr_q  <= table_base;
          addr_q <= '0;
          rem_q  <= '0;
          last_q <= 1'b0;
          dir_q  <= to_mem;
          left_q <= dev_bytes;
          st     <= S_CHECK;
        end
        S_CHECK: begin
          if (left_q == '0) begin
            done_ok <= 1'b1;
            st      <= S_IDLE;
          end else if (rem_q != '0) begin
            st <= S_CREQ;
          end else if (last_q || guard_hit) begin
            done_exh <= 1'b1;
            st       <= S_IDLE;
          end else begin
            st <= S_FREQ;
          end
        end
        S_FREQ: if (mreq_ready) begin
          ptr_q <= ptr_q + AW'(DESC_BYTES);
          st    <= S_FWAIT;
        end
        S_FWAIT: if (mrsp_valid) begin
          addr_q <= AW'(mrsp_data[31:0]);
          rem_q  <= new_len;
          last_q <= mrsp_data[63];
          st     <= S_CHECK;
        end
        S_CREQ: if (mreq_ready) begin
          addr_q <= addr_q + AW'(chunk);
          rem_q  <= rem_q - chunk;
          left_q <= left_q - DEV_W'(chunk);
          st     <= S_CHECK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_desc_walker_chk.sv
module sg_desc_walker_chk #(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 4096
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] table_base,
  input logic          busy,
  input logic          mreq_valid,
  input logic          mreq_ready,
  input logic          mreq_desc,
  input logic          mreq_write,
  input logic [AW-1:0] mreq_addr,
  input logic [16:0]   mreq_len,
  input logic          mrsp_valid,
  input logic          done_ok,
  input logic          done_exh
);
  logic          pend_q;
  logic [AW-1:0] base_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      base_cap <= '0;
    end else begin
      if (start && !busy) base_cap <= table_base;
      if (mreq_valid && mreq_ready && mreq_desc) pend_q <= 1'b1;
      else if (mrsp_valid) pend_q <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_len) && $stable(mreq_desc)); // R10
  AST_ONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !mreq_valid); // R10
  AST_DESC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_desc |-> mreq_len == 17'd8 && !mreq_write); // R2
  AST_CHUNK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_desc |-> mreq_len != 17'd0 && mreq_len <= 17'd65536); // R7
  AST_PAGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_desc |-> (mreq_addr - base_cap) < AW'(PAGE_BYTES)); // R6
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_exh)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mreq_valid); // R1
endmodule

bind sg_desc_walker sg_desc_walker_chk #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base), .busy(busy),
  .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_desc(mreq_desc),
  .mreq_write(mreq_write), .mreq_addr(mreq_addr), .mreq_len(mreq_len),
  .mrsp_valid(mrsp_valid), .done_ok(done_ok), .done_exh(done_exh)
);

// File: tb/sg_desc_walker_bench.sv
module sg_desc_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] table_base = '0;
  logic [19:0] dev_bytes = '0;
  logic        to_mem = 1'b0;
  logic        busy, mreq_valid, mreq_desc, mreq_write, done_ok, done_exh;
  logic        mreq_ready = 1'b1;
  logic [31:0] mreq_addr;
  logic [16:0] mreq_len;
  logic        mrsp_valid = 1'b0;
  logic [63:0] mrsp_data = '0;

  always #4 clk = ~clk;

  sg_desc_walker u_sg_desc_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
    .dev_bytes(dev_bytes), .to_mem(to_mem), .busy(busy),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_desc(mreq_desc),
    .mreq_write(mreq_write), .mreq_addr(mreq_addr), .mreq_len(mreq_len),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data),
    .done_ok(done_ok), .done_exh(done_exh)
  );

  int checks = 0;
  int failures = 0;
  logic [31:0] d_addr [512];
  logic [31:0] d_size [512];
  logic [31:0] g_addr [600];
  logic [16:0] g_len  [600];
  logic        g_wr   [600];
  logic [31:0] e_addr [600];
  logic [16:0] e_len  [600];
  int n_chunk, n_fetch, e_chunk, e_fetch;
  logic got_exh, exp_exh, ended;

  // {scenario, base, dev_bytes, dir, stall, expected chunks, expected exhausted}
  localparam logic [74:0] VEC [8] = '{
    {4'd0, 32'h0001_0000, 20'd512,   1'b1, 1'b0, 16'd1,   1'b0},
    {4'd1, 32'h0002_0008, 20'd1024,  1'b0, 1'b1, 16'd2,   1'b1},
    {4'd3, 32'h0003_0000, 20'd100,   1'b1, 1'b0, 16'd2,   1'b0},
    {4'd0, 32'h0001_0000, 20'd512,   1'b0, 1'b0, 16'd1,   1'b0},
    {4'd2, 32'h0004_0000, 20'd70000, 1'b1, 1'b0, 16'd1,   1'b1},
    {4'd4, 32'h0005_0000, 20'd5000,  1'b0, 1'b0, 16'd512, 1'b1},
    {4'd0, 32'h0006_0000, 20'd0,     1'b1, 1'b0, 16'd0,   1'b0},
    {4'd0, 32'h0007_0000, 20'd300,   1'b1, 1'b1, 16'd1,   1'b0}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_table(input int scen);
    for (int i = 0; i < 512; i++) begin d_addr[i] = '0; d_size[i] = '0; end
    case (scen)
      0: begin d_addr[0] = 32'h1000_0000; d_size[0] = 32'h8000_0200; end
      1: begin d_addr[0] = 32'h0000_2000; d_size[0] = 32'h0000_0101;
               d_addr[1] = 32'h0000_3000; d_size[1] = 32'h8000_0100; end
      2: begin d_addr[0] = 32'h0004_0000; d_size[0] = 32'h8000_0000; end
      3: begin d_addr[0] = 32'h0000_5000; d_size[0] = 32'h0000_0040;
               d_addr[1] = 32'h0000_6000; d_size[1] = 32'h8000_0100; end
      default: for (int i = 0; i < 512; i++) begin
        d_addr[i] = 32'h7000_0000 + 32'(i * 16); d_size[i] = 32'h0000_0002;
      end
    endcase
  endtask

  task automatic build_expect(input logic [31:0] base, input int dev);
    logic [31:0] ptr, cadr, sz;
    int rem, dv, c, cnt;
    logic last;
    ptr = base; rem = 0; dv = dev; last = 1'b0; cadr = '0;
    e_chunk = 0; e_fetch = 0; exp_exh = 1'b0;
    forever begin
      if (dv == 0) break;
      if (rem == 0) begin
        if (last || (ptr - base) >= 32'd4096) begin exp_exh = 1'b1; break; end
        cadr = d_addr[(ptr - base) >> 3];
        sz   = d_size[(ptr - base) >> 3];
        ptr += 8; e_fetch++;
        cnt = int'(sz[15:0] & 16'hFFFE);
        rem = (cnt == 0) ? 65536 : cnt;
        last = sz[31];
      end
      c = (dv < rem) ? dv : rem;
      e_addr[e_chunk] = cadr; e_len[e_chunk] = 17'(c); e_chunk++;
      cadr += 32'(c); rem -= c; dv -= c;
    end
  endtask

  task automatic run_walk(input logic [31:0] base, input int dev, input bit dir, input bit stall);
    bit pend = 1'b0;
    int cyc = 0;
    n_chunk = 0; n_fetch = 0; got_exh = 1'b0; ended = 1'b0;
    @(negedge clk);
    table_base = base; dev_bytes = 20'(dev); to_mem = dir; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!ended && cyc < 20000) begin
      mrsp_valid = 1'b0;
      if (pend) begin
        mrsp_valid = 1'b1;
        mrsp_data  = {d_size[(mreq_addr_last - base) >> 3], d_addr[(mreq_addr_last - base) >> 3]};
        pend = 1'b0;
      end
      if (done_ok || done_exh) begin
        ended = 1'b1; got_exh = done_exh;
        chk(!(done_ok && done_exh), "R8 single end pulse", done_ok + done_exh, 1);
      end
      mreq_ready = stall ? cyc[0] : 1'b1;
      if (mreq_valid && mreq_ready) begin
        if (mreq_desc) begin
          chk(mreq_addr == base + 32'(8 * n_fetch) && mreq_len == 17'd8 && !mreq_write,
              stall ? "R2/R5/R10 fetch address" : "R2/R5 fetch address",
              mreq_addr, base + 32'(8 * n_fetch));
          mreq_addr_last = mreq_addr;
          n_fetch++; pend = 1'b1;
        end else if (n_chunk < 600) begin
          g_addr[n_chunk] = mreq_addr; g_len[n_chunk] = mreq_len; g_wr[n_chunk] = mreq_write;
          n_chunk++;
        end
      end
      cyc++;
      @(negedge clk);
    end
    mreq_ready = 1'b1; mrsp_valid = 1'b0;
    chk(ended, "watchdog walk end", cyc, 0);
  endtask

  logic [31:0] mreq_addr_last = '0;

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mreq_valid && !done_ok && !done_exh, "R1 reset state",
        {busy, mreq_valid, done_ok, done_exh}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mreq_valid, "R1 idle after reset", {busy, mreq_valid}, 0);

    for (int v = 0; v < 8; v++) begin
      int scen = int'(VEC[v][74:71]);
      logic [31:0] base = VEC[v][70:39];
      int dev = int'(VEC[v][38:19]);
      bit dir = VEC[v][18];
      bit stall = VEC[v][17];
      int vch = int'(VEC[v][16:1]);
      bit vex = VEC[v][0];
      set_table(scen);
      build_expect(base, dev);
      run_walk(base, dev, dir, stall);
      chk(n_chunk == vch, v == 3 ? "R9 chunk count after restart" :
          (stall ? "R10 chunk count with stalls" : "R7 vector chunk count"), n_chunk, vch);
      chk(got_exh == vex, vex ? (scen == 4 ? "R6 page guard end" : "R4 final flag end")
                              : (dev == 0 ? "R8 zero-byte start" : "R8 drained end"), got_exh, vex);
      chk(n_chunk == e_chunk, "R7 model chunk count", n_chunk, e_chunk);
      chk(n_fetch == e_fetch, "R5 fetch count", n_fetch, e_fetch);
      chk(got_exh == exp_exh, "R4/R6 model end kind", got_exh, exp_exh);
      for (int k = 0; k < n_chunk && k < e_chunk; k++) begin
        chk(g_addr[k] == e_addr[k], "R7 chunk address", g_addr[k], e_addr[k]);
        chk(g_len[k] == e_len[k], "R3/R7 chunk length", g_len[k], e_len[k]);
        chk(g_wr[k] == dir, "R7 chunk direction", g_wr[k], dir);
      end
      @(negedge clk);
      chk(!busy && !mreq_valid, "R1 idle after walk", {busy, mreq_valid}, 0);
    end

    set_table(2);
    run_walk(32'h0008_0000, 70000, 1'b0, 1'b0);
    chk(n_chunk == 1 && g_len[0] == 17'd65536, "R3 zero count means 65536", g_len[0], 65536);
    set_table(1);
    run_walk(32'h0009_0000, 256, 1'b1, 1'b0);
    chk(n_chunk == 1 && g_len[0] == 17'd256 && !got_exh, "R3 bit0 ignored", g_len[0], 256);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule